// File: doc/BRIEF.md
# Telecom Bus Receive Marker Generator

This block drives the per-byte timing markers of an 8-bit receive telecom bus that carries a single STS-3c/STM-1 stream at one byte per clock (19.44 MHz line rate). A frame-start input marks the first A1 byte. From that point the block walks the byte position through a 9-row by 270-column frame. It combines that position with an already-interpreted payload pointer and with increment/decrement justification flags, and from these it produces four outputs: an SPE-active flag, a combined C1/J1 marker, a configurable parity bit and a failure indication.

The data byte is passed through untouched, for both overhead and payload, with bit 7 the first-received bit. It is registered once so that it leaves in the same cycle as its markers. A position-mode input selects the C1/J1 behaviour. With the mode set, the marker flags the first C1 byte (SPE low) and the J1 byte (SPE high). With the mode clear, the marker flags only the last A2 byte. Framing, pointer interpretation and the alarm detectors sit upstream.

Top module: `tbus_rx_mark_gen`

## Requirements
- R1: `data_o` equals `data_i` from the previous clock, unmodified. Every output has the same one-cycle latency, so each marker lines up with its data byte.
- R2: While reset is active, all outputs are low. The byte carrying `frame_start_i` is row 0, column 0, and each clock after it advances one column, through columns 0..269 and rows 0..8, wrapping at the end of the frame. A new `frame_start_i` restarts the count at any point. Until the first `frame_start_i`, `spe_o` and `c1j1_o` stay low.
- R3: With no justification, `spe_o` is high for columns 9..269 of every row and low for columns 0..8.
- R4: `ptr_dec_i` is sampled on row 3, column 5. When it is set, `spe_o` is also high on row 3, columns 6..8 (the H3 bytes) of that frame.
- R5: `ptr_inc_i` is sampled on the same byte as `ptr_dec_i`. When it is set, `spe_o` is low on row 3, columns 9..11 of that frame. If both flags are set in the same sample, neither takes effect.
- R6: With `pos_mode_i`=1, `c1j1_o` is high and `spe_o` is low on row 0, column 6 (first C1).
- R7: With `pos_mode_i`=1, `c1j1_o` is high on the J1 byte. Payload bytes (columns 9..269 only) are numbered from 0, starting at row 3, column 9. The numbering continues through rows 4..8 and then rows 0..2 of the next frame. J1 is payload number 3·P, where P is `ptr_i` as sampled on row 3, column 5. P above 782, or a J1 byte where `spe_o` is low, gives no J1 mark.
- R8: With `pos_mode_i`=0, `c1j1_o` is high only on row 0, column 5 (last A2), and never together with `spe_o`.
- R9: `par_o` is 0 when `par_en_i`=0. Otherwise let X be the XOR of the 8 data bits of the output byte, also XORed with `spe_o` and `c1j1_o` of that byte when `par_full_i`=1. `par_o` is X when `par_even_i`=1 and the inverse of X when `par_even_i`=0.
- R10: `fail_o` is the OR of `lop_i`, `ais_p_i`, `ais_l_i`, `loc_i` and `lod_i` from the previous clock, and stays high for as long as any of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | High on the first A1 byte of a frame |
| data_i | input | 8 | Received byte, bit 7 first |
| ptr_i | input | 10 | Interpreted payload pointer |
| ptr_inc_i | input | 1 | Pointer increment in this frame |
| ptr_dec_i | input | 1 | Pointer decrement in this frame |
| lop_i | input | 1 | Loss of pointer |
| ais_p_i | input | 1 | Path AIS |
| ais_l_i | input | 1 | Line AIS |
| loc_i | input | 1 | Loss of clock |
| lod_i | input | 1 | Loss of data |
| pos_mode_i | input | 1 | 1: C1 and J1 marking, 0: last-A2 marking |
| par_en_i | input | 1 | Parity enable |
| par_even_i | input | 1 | 1: even parity, 0: odd |
| par_full_i | input | 1 | 1: parity also covers SPE and C1J1 |
| data_o | output | 8 | Delayed data byte |
| spe_o | output | 1 | Payload byte flag |
| c1j1_o | output | 1 | C1/J1 or last-A2 marker |
| par_o | output | 1 | Parity bit |
| fail_o | output | 1 | Failure indication |

## Verification
The J1 marker and the increment's SPE suppression can claim the same byte. This happens when the pointer is 0 and an increment is flagged: J1 then falls on row 3, column 9, which is one of the three bytes the increment forces low. The bench drives that frame directly and expects `c1j1_o` low together with `spe_o` low on that byte. Full-coverage parity on the same byte confirms that both suppressed markers feed the parity bit. Random frames mix pointer values, both justification flags, parity settings and alarms against a bench model.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  localparam int ROWS    = 9;
  localparam int PTR_ROW = 3;

  typedef struct packed {
    logic lop;
    logic ais_p;
    logic ais_l;
    logic loc;
    logic lod;
  } alarm_t;

  typedef struct packed {
    logic spe;
    logic c1j1;
  } mark_t;
endpackage

// File: rtl/tbm_pos_cnt.sv
module tbm_pos_cnt #(
  parameter int COLS = 270,
  parameter int ROWS = 9,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             sync_o
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             sync_q;

  // position of the byte presented this cycle
  always_comb begin
    row_o  = frame_start_i ? '0 : row_q;
    col_o  = frame_start_i ? '0 : col_q;
    sync_o = frame_start_i | sync_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_o;
      if (int'(col_o) == COLS - 1) begin
        col_q <= '0;
        row_q <= (int'(row_o) == ROWS - 1) ? '0 : row_o + 1'b1;
      end else begin
        col_q <= col_o + 1'b1;
        row_q <= row_o;
      end
    end
  end

  p_col_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(col_q) < COLS && int'(row_q) < ROWS);

  p_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (col_q == COL_W'(1) && row_q == '0));
endmodule

// File: rtl/tbm_mark_gen.sv
module tbm_mark_gen
  import tbm_pkg::*;
#(
  parameter int STS_N = 3,
  parameter int PTR_W = 10,
  parameter int COLS  = 90 * STS_N,
  parameter int ROWS  = 9,
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             sync_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             pos_mode_i,
  output mark_t            mark_o
);
  localparam int OH_COLS   = 3 * STS_N;
  localparam int PAY_COLS  = COLS - OH_COLS;
  localparam int PAY_BYTES = PAY_COLS * ROWS;
  localparam int PTR_MAX   = PAY_BYTES / STS_N - 1;
  localparam int A2_LAST   = 2 * STS_N - 1;
  localparam int C1_FIRST  = 2 * STS_N;
  localparam int H2_LAST   = 2 * STS_N - 1;
  localparam int H3_FIRST  = 2 * STS_N;
  localparam int INC_LAST  = OH_COLS + STS_N - 1;

  logic [PTR_W-1:0] ptr_q;
  logic             ptr_ok_q, inc_q, dec_q;
  logic             is_pay, in_ptr_row, spe, j1, c1;
  int               row_n, col_n, rrel, idx;

  always_comb begin
    row_n      = int'(row_i);
    col_n      = int'(col_i);
    is_pay     = col_n >= OH_COLS;
    in_ptr_row = row_n == PTR_ROW;
    // payload numbering restarts right after the last H3 byte
    rrel = (row_n >= PTR_ROW) ? row_n - PTR_ROW : row_n + ROWS - PTR_ROW;
    idx  = rrel * PAY_COLS + col_n - OH_COLS;

    spe = sync_i && is_pay;
    if (in_ptr_row && dec_q && col_n >= H3_FIRST && col_n < OH_COLS) spe = 1'b1;
    if (in_ptr_row && inc_q && col_n >= OH_COLS && col_n <= INC_LAST) spe = 1'b0;

    j1 = pos_mode_i && sync_i && is_pay && ptr_ok_q && spe &&
         (int'(ptr_q) <= PTR_MAX) && (idx == int'(ptr_q) * STS_N);
    c1 = sync_i && (row_n == 0) && (col_n == (pos_mode_i ? C1_FIRST : A2_LAST));

    mark_o.spe  = spe;
    mark_o.c1j1 = c1 | j1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      ptr_ok_q <= 1'b0;
      inc_q    <= 1'b0;
      dec_q    <= 1'b0;
    end else if (sync_i && in_ptr_row && col_n == H2_LAST) begin
      ptr_q    <= ptr_i;
      ptr_ok_q <= 1'b1;
      inc_q    <= inc_i & ~dec_i;
      dec_q    <= dec_i & ~inc_i;
    end
  end

  p_c1_oh_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && pos_mode_i && row_n == 0 && col_n == C1_FIRST) |-> (mark_o.c1j1 && !mark_o.spe));

  p_nosync_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |-> (mark_o == '0));

  p_idx_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pay |-> (idx >= 0 && idx < PAY_BYTES));
endmodule

// File: rtl/tbm_par_gen.sv
module tbm_par_gen
  import tbm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  mark_t             mark_i,
  input  logic              en_i,
  input  logic              even_i,
  input  logic              full_i,
  output logic              par_o
);
  logic bits;

  always_comb begin
    bits  = ^data_i ^ (full_i & (mark_i.spe ^ mark_i.c1j1));
    par_o = en_i & (even_i ? bits : ~bits);
  end
endmodule

// File: rtl/tbus_rx_mark_gen.sv
module tbus_rx_mark_gen
  import tbm_pkg::*;
#(
  parameter int STS_N  = 3,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              ptr_inc_i,
  input  logic              ptr_dec_i,
  input  logic              lop_i,
  input  logic              ais_p_i,
  input  logic              ais_l_i,
  input  logic              loc_i,
  input  logic              lod_i,
  input  logic              pos_mode_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              par_full_i,
  output logic [DATA_W-1:0] data_o,
  output logic              spe_o,
  output logic              c1j1_o,
  output logic              par_o,
  output logic              fail_o
);
  localparam int COLS  = 90 * STS_N;
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);

  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic             sync;
  mark_t            mark;
  logic             par_d;
  alarm_t           alarms;

  assign alarms = '{lop: lop_i, ais_p: ais_p_i, ais_l: ais_l_i, loc: loc_i, lod: lod_i};

  tbm_pos_cnt #(.COLS(COLS), .ROWS(ROWS)) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
    .row_o(row), .col_o(col), .sync_o(sync)
  );

  tbm_mark_gen #(.STS_N(STS_N), .PTR_W(PTR_W), .COLS(COLS), .ROWS(ROWS)) u_mark (
    .clk_i(clk_i), .rst_ni(rst_ni), .row_i(row), .col_i(col), .sync_i(sync),
    .ptr_i(ptr_i), .inc_i(ptr_inc_i), .dec_i(ptr_dec_i), .pos_mode_i(pos_mode_i),
    .mark_o(mark)
  );

  tbm_par_gen #(.DATA_W(DATA_W)) u_par (
    .data_i(data_i), .mark_i(mark), .en_i(par_en_i), .even_i(par_even_i),
    .full_i(par_full_i), .par_o(par_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      spe_o  <= 1'b0;
      c1j1_o <= 1'b0;
      par_o  <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      data_o <= data_i;
      spe_o  <= mark.spe;
      c1j1_o <= mark.c1j1;
      par_o  <= par_d;
      fail_o <= |alarms;
    end
  end

  p_fail_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lop_i || ais_p_i || ais_l_i || loc_i || lod_i) |=> fail_o);

  p_fail_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lop_i || ais_p_i || ais_l_i || loc_i || lod_i) |=> !fail_o);

  p_par_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_en_i |=> !par_o);

  p_a2_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pos_mode_i |=> !(c1j1_o && spe_o));
endmodule

// File: tb/tbus_rx_mark_gen_bench.sv
`timescale 1ns/1ps
module tbus_rx_mark_gen_bench;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       frame_start_i;
  logic [7:0] data_i;
  logic [9:0] ptr_i;
  logic       ptr_inc_i, ptr_dec_i;
  logic       lop_i, ais_p_i, ais_l_i, loc_i, lod_i;
  logic       pos_mode_i, par_en_i, par_even_i, par_full_i;
  logic [7:0] data_o;
  logic       spe_o, c1j1_o, par_o, fail_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of frame position and latched pointer state
  int m_sync, m_row, m_col, m_ptr, m_ptr_ok, m_inc, m_dec;

  always #4 clk = ~clk;

  tbus_rx_mark_gen u_tbus_rx_mark_gen (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start_i), .data_i(data_i),
    .ptr_i(ptr_i), .ptr_inc_i(ptr_inc_i), .ptr_dec_i(ptr_dec_i),
    .lop_i(lop_i), .ais_p_i(ais_p_i), .ais_l_i(ais_l_i), .loc_i(loc_i), .lod_i(lod_i),
    .pos_mode_i(pos_mode_i), .par_en_i(par_en_i), .par_even_i(par_even_i),
    .par_full_i(par_full_i), .data_o(data_o), .spe_o(spe_o), .c1j1_o(c1j1_o),
    .par_o(par_o), .fail_o(fail_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic byte_cycle(input bit fs);
    int r, c, idx;
    bit spe_e, c1_e, j1_e, cj_e, bits, par_e, fail_e;
    logic [7:0] d;
    string spe_req, cj_req;
    frame_start_i = fs;
    data_i     = 8'($urandom);
    lop_i      = ($urandom % 30) == 0;
    ais_p_i    = ($urandom % 30) == 0;
    ais_l_i    = ($urandom % 30) == 0;
    loc_i      = ($urandom % 30) == 0;
    lod_i      = ($urandom % 30) == 0;
    par_en_i   = ($urandom % 4) != 0;
    par_even_i = 1'($urandom);
    par_full_i = 1'($urandom);
    if (fs) begin m_sync = 1; m_row = 0; m_col = 0; end
    r = m_row; c = m_col;
    spe_e = (m_sync != 0) && c >= 9;
    if (m_sync != 0 && r == 3 && c >= 6 && c <= 8 && m_dec != 0) spe_e = 1;
    if (m_sync != 0 && r == 3 && c >= 9 && c <= 11 && m_inc != 0) spe_e = 0;
    idx = ((r * 261 + c - 9) - 783 + 2349) % 2349;
    j1_e = pos_mode_i && m_sync != 0 && c >= 9 && m_ptr_ok != 0 && m_ptr <= 782 &&
           idx == 3 * m_ptr && spe_e;
    c1_e = m_sync != 0 && r == 0 && (pos_mode_i ? c == 6 : c == 5);
    cj_e = c1_e | j1_e;
    bits = (^data_i) ^ (par_full_i ? (spe_e ^ cj_e) : 1'b0);
    par_e = par_en_i ? (par_even_i ? bits : !bits) : 1'b0;
    fail_e = lop_i | ais_p_i | ais_l_i | loc_i | lod_i;
    d = data_i;
    if (m_sync != 0 && r == 3 && c == 5) begin
      m_ptr = int'(ptr_i); m_ptr_ok = 1;
      m_inc = (ptr_inc_i && !ptr_dec_i) ? 1 : 0;
      m_dec = (ptr_dec_i && !ptr_inc_i) ? 1 : 0;
    end
    m_col++;
    if (m_col == 270) begin m_col = 0; m_row = (m_row + 1) % 9; end
    if (m_sync == 0) spe_req = "R2 spe before sync";
    else if (r == 3 && c >= 6 && c <= 8) spe_req = "R4 spe on H3";
    else if (r == 3 && c >= 9 && c <= 11) spe_req = "R5 spe after H3";
    else spe_req = "R3 spe";
    if (m_sync == 0) cj_req = "R2 c1j1 before sync";
    else if (!pos_mode_i) cj_req = "R8 c1j1 last A2";
    else if (r == 0 && c == 6) cj_req = "R6 c1j1 on C1";
    else cj_req = "R7 c1j1 J1";
    @(posedge clk); #2;
    chk(data_o == d, "R1 data", int'(data_o), int'(d));
    chk(spe_o == spe_e, spe_req, int'(spe_o), int'(spe_e));
    chk(c1j1_o == cj_e, cj_req, int'(c1j1_o), int'(cj_e));
    chk(par_o == par_e, "R9 parity", int'(par_o), int'(par_e));
    chk(fail_o == fail_e, "R10 fail", int'(fail_o), int'(fail_e));
  endtask

  task automatic run_frame(input int p, input bit inc, input bit dec, input bit mode, input int nb);
    ptr_i = 10'(p); ptr_inc_i = inc; ptr_dec_i = dec; pos_mode_i = mode;
    byte_cycle(1'b1);
    for (int i = 1; i < nb; i++) byte_cycle(1'b0);
  endtask

  initial begin
    void'($urandom(32'h1f3c_5a07));
    m_sync = 0; m_row = 0; m_col = 0; m_ptr = 0; m_ptr_ok = 0; m_inc = 0; m_dec = 0;
    rst_ni = 1'b0; frame_start_i = 1'b0; data_i = '0; ptr_i = '0;
    ptr_inc_i = 1'b0; ptr_dec_i = 1'b0; lop_i = 1'b0; ais_p_i = 1'b0; ais_l_i = 1'b0;
    loc_i = 1'b0; lod_i = 1'b0; pos_mode_i = 1'b1; par_en_i = 1'b1; par_even_i = 1'b1;
    par_full_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      data_i = 8'($urandom); lop_i = 1'b1;
      @(posedge clk); #2;
      chk(data_o == 8'h00, "R2 reset data", int'(data_o), 0);
      chk({spe_o, c1j1_o, par_o, fail_o} == 4'b0, "R2 reset markers",
          int'({spe_o, c1j1_o, par_o, fail_o}), 0);
    end
    rst_ni = 1'b1;
    // no frame start yet: markers stay quiet
    for (int i = 0; i < 20; i++) byte_cycle(1'b0);
    // directed corner cases
    run_frame(0,   0, 0, 1, 2430);
    run_frame(782, 0, 0, 1, 2430);
    run_frame(5,   0, 1, 1, 2430);
    run_frame(100, 1, 0, 1, 2430);
    run_frame(0,   1, 0, 1, 2430);  // J1 collides with increment window
    run_frame(800, 0, 0, 1, 2430);  // out of range pointer
    run_frame(50,  1, 1, 1, 2430);  // both flags cancel
    run_frame(50,  0, 0, 0, 2430);  // last A2 mode
    run_frame(260, 0, 1, 0, 2430);
    run_frame(700, 0, 0, 1, 1000);  // mid-frame restart follows
    run_frame(3,   0, 0, 1, 2430);
    for (int f = 0; f < 4; f++)
      run_frame(int'($urandom % 790), 1'($urandom), 1'($urandom), 1'($urandom), 2430);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule